// File: doc/BRIEF.md
# Logical Shift Execution Unit

This unit performs logical (zero-filling) shifts for a DSP-style datapath. It handles four operand classes: 32-bit address pointers, 32-bit data words, 16-bit half-word lanes taken from a 32-bit register, and 40-bit accumulators. Vacated bit positions are always filled with zeros, so the sign of a negative operand is never kept. Bits shifted out past the top of the operand are discarded.

The shift amount comes from one of two places. It can be an immediate field with an explicit direction bit. It can also be a signed 16-bit count supplied from a register, where a count of zero or more shifts left and a negative count shifts right by its magnitude. Pointer shifts ignore the register count and allow only a distance of 1 or 2. For half-word operations, the caller picks which half of the source feeds the shifter and which half of the destination receives the result. The other destination half is taken unchanged from the old destination value.

The result is captured in an output register on a clock edge where the valid strobe is high. A synchronous reset clears that register.

Top module: `lsh_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q` becomes all zeros on that edge.
- R2: On a rising edge with `valid` low and `rst` low, `res_q` keeps its value whatever the other inputs are.
- R3: With `op_class`=2'b00 (pointer), the operand is `src_data[31:0]`. The distance is 2 when `imm_amt[0]`=1 and 1 otherwise. The direction is left when `imm_left`=1. `amt_reg`, `reg_cnt` and `imm_amt[5:1]` have no effect.
- R4: With `op_class`=2'b01 (word) and `amt_reg`=0, `src_data[31:0]` is shifted by `imm_amt` (0..63) in the direction set by `imm_left`. `res_q[39:32]` is zero for every class except the accumulator class.
- R5: With `amt_reg`=1 (for classes other than pointer), `reg_cnt` is read as a signed two's-complement count. A value of zero or more shifts left by that value, and a negative value shifts right by its magnitude, including magnitude 32768 for 16'h8000.
- R6: With `op_class`=2'b10 (half), the 16-bit operand is `src_data[31:16]` when `src_hi`=1 and `src_data[15:0]` when `src_hi`=0.
- R7: A half-word result goes to `res_q[31:16]` when `dst_hi`=1 and to `res_q[15:0]` when `dst_hi`=0. The other half of `res_q[31:0]` equals the matching half of `dst_old`.
- R8: With `op_class`=2'b11 (accumulator), all 40 bits of `src_data` are shifted, and bits moved beyond bit 39 are dropped.
- R9: Every shift is logical: vacated bits are zero. A shift whose magnitude is at least the operand width (16, 32 or 40) gives zero. For example, a half-word 16'hFFC0 shifted right by 4 gives 16'h0FFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Capture a new result on this edge |
| op_class | input | 2 | 00 pointer, 01 word, 10 half, 11 accumulator |
| amt_reg | input | 1 | 1: use signed `reg_cnt`; 0: use immediate |
| imm_amt | input | 6 | Immediate shift magnitude |
| imm_left | input | 1 | Immediate direction, 1 = left |
| reg_cnt | input | 16 | Signed register-supplied count |
| src_data | input | 40 | Source operand (low 32 bits for 32/16-bit classes) |
| src_hi | input | 1 | Half-word source select, 1 = upper half |
| dst_hi | input | 1 | Half-word destination select, 1 = upper half |
| dst_old | input | 32 | Current destination value, kept in the unwritten half |
| res_q | output | 40 | Registered result |

## Verification
The assertions check the following on every cycle: the reset clear, holding while `valid` is low, zero upper bits for 32- and 16-bit classes, preservation of the untouched destination half, the population bound on pointer results, and an all-zero word result for register counts of magnitude 32 or more. The exact shifted values, the source-half selection, the meaning of the count's sign, and the accumulator's 40-bit span are shown only by the bench's scenarios, which compare against a behavioural model. These scenarios include the 16'hFFC0 example, the counts 16'h8000 and ±32, and the width boundaries 16/32/40.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
    typedef enum logic [1:0] {
        CLS_PTR  = 2'b00,
        CLS_WORD = 2'b01,
        CLS_HALF = 2'b10,
        CLS_ACC  = 2'b11
    } op_cls_e;
endpackage

// File: rtl/lsh_amount.sv
module lsh_amount #(
    parameter int IMM_W = 6,
    parameter int CNT_W = 16,
    parameter int MAG_W = CNT_W + 1
) (
    input  logic             is_ptr,
    input  logic             use_reg,
    input  logic [IMM_W-1:0] imm_mag,
    input  logic             imm_left,
    input  logic [CNT_W-1:0] reg_cnt,
    output logic             left,
    output logic [MAG_W-1:0] mag
);
    logic             neg;
    logic [MAG_W-1:0] ext;

    always_comb begin
        neg = reg_cnt[CNT_W-1];
        ext = {{(MAG_W-CNT_W){neg}}, reg_cnt};
        if (is_ptr) begin
            // pointer distance: only 1 or 2
            left = imm_left;
            mag  = imm_mag[0] ? MAG_W'(2) : MAG_W'(1);
        end else if (use_reg) begin
            // sign picks direction, magnitude from two's complement
            left = !neg;
            mag  = neg ? (~ext + MAG_W'(1)) : ext;
        end else begin
            left = imm_left;
            mag  = MAG_W'(imm_mag);
        end
    end
endmodule

// File: rtl/lsh_core.sv
module lsh_core #(
    parameter int W     = 32,
    parameter int MAG_W = 17
) (
    input  logic [W-1:0]     din,
    input  logic             left,
    input  logic [MAG_W-1:0] mag,
    output logic [W-1:0]     dout
);
    always_comb begin
        if (mag >= MAG_W'(W))
            dout = '0;
        else if (left)
            dout = din << mag;
        else
            dout = din >> mag;
    end
endmodule

// File: rtl/lsh_unit.sv
module lsh_unit #(
    parameter int ACC_W  = 40,
    parameter int WORD_W = 32,
    parameter int IMM_W  = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [1:0]        op_class,
    input  logic              amt_reg,
    input  logic [IMM_W-1:0]  imm_amt,
    input  logic              imm_left,
    input  logic [CNT_W-1:0]  reg_cnt,
    input  logic [ACC_W-1:0]  src_data,
    input  logic              src_hi,
    input  logic              dst_hi,
    input  logic [WORD_W-1:0] dst_old,
    output logic [ACC_W-1:0]  res_q
);
    import lsh_pkg::*;

    localparam int HALF_W = WORD_W / 2;
    localparam int MAG_W  = CNT_W + 1;
    localparam int NLANE  = 3;

    typedef struct packed {
        logic [ACC_W-1:0] res;
    } state_t;

    state_t           st_d, st_q;
    op_cls_e          cls;
    logic             sh_left;
    logic [MAG_W-1:0] sh_mag;
    logic [HALF_W-1:0] half_src;

    assign cls      = op_cls_e'(op_class);
    assign half_src = src_hi ? src_data[WORD_W-1:HALF_W] : src_data[HALF_W-1:0];

    lsh_amount #(.IMM_W(IMM_W), .CNT_W(CNT_W), .MAG_W(MAG_W)) u_amt (
        .is_ptr   (cls == CLS_PTR),
        .use_reg  (amt_reg),
        .imm_mag  (imm_amt),
        .imm_left (imm_left),
        .reg_cnt  (reg_cnt),
        .left     (sh_left),
        .mag      (sh_mag)
    );

    // lane 0: half word, lane 1: word/pointer, lane 2: accumulator
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF_W : ((g == 1) ? WORD_W : ACC_W);
        logic [LW-1:0] din_w;
        logic [LW-1:0] dout_w;
        if (g == 0) begin : g_half_in
            assign din_w = half_src;
        end else begin : g_full_in
            assign din_w = src_data[LW-1:0];
        end
        lsh_core #(.W(LW), .MAG_W(MAG_W)) u_core (
            .din  (din_w),
            .left (sh_left),
            .mag  (sh_mag),
            .dout (dout_w)
        );
    end

    always_comb begin
        st_d = st_q;
        if (valid) begin
            st_d.res = '0;
            unique case (cls)
                CLS_PTR, CLS_WORD: st_d.res[WORD_W-1:0] = g_lane[1].dout_w;
                CLS_HALF: begin
                    st_d.res[WORD_W-1:0] = dst_old;
                    if (dst_hi)
                        st_d.res[WORD_W-1:HALF_W] = g_lane[0].dout_w;
                    else
                        st_d.res[HALF_W-1:0] = g_lane[0].dout_w;
                end
                CLS_ACC: st_d.res = g_lane[2].dout_w;
                default: st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_q = st_q.res;
endmodule

// File: rtl/lsh_chk.sv
module lsh_chk #(
    parameter int ACC_W  = 40,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              valid,
    input logic [1:0]        op_class,
    input logic              amt_reg,
    input logic [CNT_W-1:0]  reg_cnt,
    input logic [ACC_W-1:0]  src_data,
    input logic              dst_hi,
    input logic [WORD_W-1:0] dst_old,
    input logic [ACC_W-1:0]  res_q
);
    localparam int HALF_W = WORD_W / 2;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (res_q == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(res_q));

    assert_ptr_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && op_class == 2'b00) |=>
        ($countones(res_q[WORD_W-1:0]) <= $countones($past(src_data[WORD_W-1:0]))));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && op_class != 2'b11) |=> (res_q[ACC_W-1:WORD_W] == '0));

    assert_wide_count_R5: assert property (@(posedge clk) disable iff (rst)
        (valid && op_class == 2'b01 && amt_reg &&
         ($signed(reg_cnt) >= 32 || $signed(reg_cnt) <= -32)) |=> (res_q == '0));

    assert_keep_low_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && op_class == 2'b10 && dst_hi) |=>
        (res_q[HALF_W-1:0] == $past(dst_old[HALF_W-1:0])));

    assert_keep_high_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && op_class == 2'b10 && !dst_hi) |=>
        (res_q[WORD_W-1:HALF_W] == $past(dst_old[WORD_W-1:HALF_W])));
endmodule

bind lsh_unit lsh_chk #(.ACC_W(ACC_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid    (valid),
    .op_class (op_class),
    .amt_reg  (amt_reg),
    .reg_cnt  (reg_cnt),
    .src_data (src_data),
    .dst_hi   (dst_hi),
    .dst_old  (dst_old),
    .res_q    (res_q)
);

// File: tb/sim_lsh_unit.sv
`timescale 1ns/1ps
module sim_lsh_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [1:0]  op_class = 2'b00;
    logic        amt_reg = 1'b0;
    logic [5:0]  imm_amt = '0;
    logic        imm_left = 1'b0;
    logic [15:0] reg_cnt = '0;
    logic [39:0] src_data = '0;
    logic        src_hi = 1'b0;
    logic        dst_hi = 1'b0;
    logic [31:0] dst_old = '0;
    logic [39:0] res_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";
    string exp_req = "R1";
    logic [39:0] exp_res = '0;

    always #10 clk = ~clk;

    lsh_unit u0 (
        .clk(clk), .rst(rst), .valid(valid), .op_class(op_class),
        .amt_reg(amt_reg), .imm_amt(imm_amt), .imm_left(imm_left),
        .reg_cnt(reg_cnt), .src_data(src_data), .src_hi(src_hi),
        .dst_hi(dst_hi), .dst_old(dst_old), .res_q(res_q)
    );

    function automatic logic [39:0] model(
        input logic [1:0] c, input logic ur, input logic [5:0] imm,
        input logic l, input logic [15:0] rc, input logic [39:0] s,
        input logic shi, input logic dhi, input logic [31:0] old);
        longint unsigned v, r, mask;
        int w, m, cnt;
        bit go_left;
        logic [39:0] o;
        go_left = l;
        m = int'(imm);
        case (c)
            2'b00: begin w = 32; v = longint'(s[31:0]); m = imm[0] ? 2 : 1; end
            2'b01: begin w = 32; v = longint'(s[31:0]); end
            2'b10: begin w = 16; v = shi ? longint'(s[31:16]) : longint'(s[15:0]); end
            default: begin w = 40; v = longint'(s); end
        endcase
        if (c != 2'b00 && ur) begin
            cnt = int'($signed(rc));
            go_left = (cnt >= 0);
            m = (cnt < 0) ? -cnt : cnt;
        end
        mask = (64'd1 << w) - 64'd1;
        if (m >= w) r = 0;
        else if (go_left) r = (v << m) & mask;
        else r = v >> m;
        o = '0;
        if (c == 2'b10) begin
            o[31:0] = old;
            if (dhi) o[31:16] = r[15:0];
            else     o[15:0]  = r[15:0];
        end else begin
            o = r[39:0];
        end
        return o;
    endfunction

    always @(posedge clk) begin
        exp_req <= cur_req;
        if (rst) exp_res <= '0;
        else if (valid)
            exp_res <= model(op_class, amt_reg, imm_amt, imm_left, reg_cnt,
                             src_data, src_hi, dst_hi, dst_old);
    end

    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            checks++;
            if (res_q !== exp_res) begin
                errors++;
                $display("FAIL %s: res_q=%h expected=%h", exp_req, res_q, exp_res);
            end
        end
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic op(input string req, input logic [1:0] c, input logic ur,
                      input logic [5:0] imm, input logic l, input logic [15:0] rc,
                      input logic [39:0] s, input logic shi, input logic dhi,
                      input logic [31:0] old);
        @(negedge clk);
        cur_req = req;
        valid = 1'b1; op_class = c; amt_reg = ur; imm_amt = imm; imm_left = l;
        reg_cnt = rc; src_data = s; src_hi = shi; dst_hi = dhi; dst_old = old;
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        cur_req = req;
        valid = 1'b0;
        op_class = 2'(op_class + 1);
        imm_amt = 6'd3; imm_left = ~imm_left; amt_reg = ~amt_reg;
        src_data = ~src_data; dst_old = ~dst_old;
    endtask

    initial begin
        // R1: reset with active stimulus
        cur_req = "R1";
        valid = 1'b1; op_class = 2'b11; src_data = 40'hFF_FFFF_FFFF; imm_left = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: 0xFFC0 right by 4 -> 0x0FFC, low source, low destination
        op("R9", 2'b10, 1'b0, 6'd4, 1'b0, 16'h0, 40'h00_1234_FFC0, 1'b0, 1'b0, 32'hAAAA_5555);
        // R3: pointer distances, register count ignored
        op("R3", 2'b00, 1'b1, 6'd0, 1'b1, 16'h8000, 40'hFF_8000_0003, 1'b0, 1'b0, 32'h0);
        op("R3", 2'b00, 1'b1, 6'd1, 1'b1, 16'h0010, 40'h00_C000_0003, 1'b0, 1'b0, 32'h0);
        op("R3", 2'b00, 1'b0, 6'd62, 1'b0, 16'h0, 40'h00_8000_0007, 1'b0, 1'b0, 32'h0);
        op("R3", 2'b00, 1'b0, 6'd3, 1'b0, 16'h0, 40'h00_8000_0007, 1'b0, 1'b0, 32'h0);
        // R4: word immediate, including 31, 32, 63 and upper-bit clearing
        op("R4", 2'b01, 1'b0, 6'd17, 1'b1, 16'h0, 40'hFF_F0F0_1234, 1'b0, 1'b0, 32'h0);
        op("R4", 2'b01, 1'b0, 6'd17, 1'b0, 16'h0, 40'hFF_F0F0_1234, 1'b0, 1'b0, 32'h0);
        op("R4", 2'b01, 1'b0, 6'd31, 1'b0, 16'h0, 40'h00_8000_0000, 1'b0, 1'b0, 32'h0);
        op("R4", 2'b01, 1'b0, 6'd32, 1'b1, 16'h0, 40'h00_FFFF_FFFF, 1'b0, 1'b0, 32'h0);
        op("R4", 2'b01, 1'b0, 6'd63, 1'b0, 16'h0, 40'h00_FFFF_FFFF, 1'b0, 1'b0, 32'h0);
        op("R4", 2'b01, 1'b0, 6'd0, 1'b0, 16'h0, 40'hAB_DEAD_BEEF, 1'b0, 1'b0, 32'h0);
        // R5: signed register count
        op("R5", 2'b01, 1'b1, 6'd9, 1'b0, 16'd4, 40'h00_0F00_00F1, 1'b0, 1'b0, 32'h0);
        op("R5", 2'b01, 1'b1, 6'd9, 1'b1, 16'hFFFC, 40'h00_0F00_00F1, 1'b0, 1'b0, 32'h0);
        op("R5", 2'b01, 1'b1, 6'd9, 1'b0, 16'd0, 40'h00_1357_9BDF, 1'b0, 1'b0, 32'h0);
        op("R5", 2'b01, 1'b1, 6'd0, 1'b0, 16'd31, 40'h00_0000_0001, 1'b0, 1'b0, 32'h0);
        op("R5", 2'b01, 1'b1, 6'd0, 1'b0, 16'hFFE1, 40'h00_8000_0000, 1'b0, 1'b0, 32'h0);
        op("R5", 2'b01, 1'b1, 6'd0, 1'b0, 16'd32, 40'h00_FFFF_FFFF, 1'b0, 1'b0, 32'h0);
        op("R5", 2'b01, 1'b1, 6'd0, 1'b0, 16'hFFE0, 40'h00_FFFF_FFFF, 1'b0, 1'b0, 32'h0);
        op("R5", 2'b01, 1'b1, 6'd0, 1'b1, 16'h8000, 40'h00_FFFF_FFFF, 1'b0, 1'b0, 32'h0);
        op("R5", 2'b10, 1'b1, 6'd0, 1'b0, 16'hFFF8, 40'h00_8421_F00F, 1'b1, 1'b0, 32'h1111_2222);
        // R6: half source select
        op("R6", 2'b10, 1'b0, 6'd4, 1'b0, 16'h0, 40'h00_FFC0_0ABC, 1'b1, 1'b0, 32'h0);
        op("R6", 2'b10, 1'b0, 6'd12, 1'b1, 16'h0, 40'h00_FFC0_0ABC, 1'b0, 1'b0, 32'h0);
        op("R6", 2'b10, 1'b0, 6'd16, 1'b1, 16'h0, 40'h00_FFC0_0ABC, 1'b0, 1'b0, 32'h7777_7777);
        // R7: half destination select
        op("R7", 2'b10, 1'b0, 6'd14, 1'b1, 16'h0, 40'h00_0003_0003, 1'b1, 1'b1, 32'h1234_5678);
        op("R7", 2'b10, 1'b0, 6'd4, 1'b0, 16'h0, 40'h00_FFC0_0000, 1'b1, 1'b1, 32'h9ABC_DEF0);
        op("R7", 2'b10, 1'b0, 6'd15, 1'b0, 16'h0, 40'hFF_0000_8001, 1'b0, 1'b1, 32'hCAFE_F00D);
        // R8: accumulator span
        op("R8", 2'b11, 1'b0, 6'd25, 1'b0, 16'h0, 40'hFF_1234_5678, 1'b0, 1'b0, 32'h0);
        op("R8", 2'b11, 1'b0, 6'd7, 1'b1, 16'h0, 40'hFF_1234_5678, 1'b0, 1'b0, 32'h0);
        op("R8", 2'b11, 1'b0, 6'd39, 1'b1, 16'h0, 40'h00_0000_0001, 1'b0, 1'b0, 32'h0);
        op("R8", 2'b11, 1'b0, 6'd40, 1'b1, 16'h0, 40'hFF_FFFF_FFFF, 1'b0, 1'b0, 32'h0);
        op("R8", 2'b11, 1'b1, 6'd0, 1'b0, 16'hFFE7, 40'h80_0000_0000, 1'b0, 1'b0, 32'h0);
        op("R8", 2'b11, 1'b1, 6'd0, 1'b0, 16'd14, 40'hFF_FFFF_FFFF, 1'b0, 1'b0, 32'h0);
        // R2: idle cycles hold the last result
        for (int i = 0; i < 5; i++) idle("R2");
        // mixed traffic, compared every cycle
        for (int i = 0; i < 300; i++) begin
            op("R5", 2'($urandom), 1'($urandom), 6'($urandom), 1'($urandom),
               (i % 3 == 0) ? 16'($signed(int'($urandom % 90) - 45)) : 16'($urandom),
               {8'($urandom), 32'($urandom)}, 1'($urandom), 1'($urandom), 32'($urandom));
            if (i % 7 == 0) idle("R2");
        end
        // R1: reset again mid-stream
        @(negedge clk);
        cur_req = "R1";
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule